// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches a byte-wide receive stream and decides, once per frame, whether the frame is kept. It reads the six destination address bytes and classifies the frame as broadcast, multicast or unicast. It then applies, in a fixed priority, broadcast handling, either a group hash lookup or recognition of the reserved flow-control address, and finally an exact station match followed by an individual hash lookup. A promiscuous fallback keeps any frame that nothing matched and marks it as a miss.

When flow control is enabled and the destination is either the reserved flow-control address or the station's own address, the filter waits for the type and opcode fields. A genuine flow-control frame is then dropped and flagged. The result leaves as a one-cycle strobe carrying accept, miss and pause flags. Checking the frame check sequence, storing frames and flushing them are handled by neighbouring blocks.

Top module: `rx_addr_filter`

## Requirements
- R1: The first destination byte received goes to bits [47:40] of the 48-bit address, and the last one goes to bits [7:0]. Bit 0 of the first byte (address bit 40) set means multicast and clear means unicast. A multicast frame never uses the individual hash table.
- R2: An all-ones destination is accepted with miss clear whenever `bc_rej` is low, regardless of the other controls.
- R3: With `bc_rej` high, a broadcast frame is accepted with miss set if `prom_en` is high, and rejected otherwise.
- R4: With `fc_en` low, a multicast frame is accepted with miss clear when its bit is set in `grp_tbl`.
- R5: The hash index is the top 6 bits [31:26] of a CRC-32 over the six address bytes. The CRC uses polynomial 0x04C11DB7, starts from all ones, has no final inversion, and takes each byte least significant bit first. The index selects bit `grp_tbl[index]` or `ind_tbl[index]`.
- R6: With `fc_en` high, a multicast frame is matched only against 01:80:C2:00:00:01. If bytes 13-14 equal 0x8808 and bytes 15-16 equal 0x0001, the frame is rejected with pause set. Otherwise it is accepted with miss clear. Any other multicast frame goes to the fallback.
- R7: With `fc_en` high, a frame addressed to `sta_addr` is also checked for the flow-control type and opcode, and is rejected with pause set if they match. With `fc_en` low, such a frame is accepted at once.
- R8: A unicast frame equal to `sta_addr` is accepted with miss clear. Otherwise, a set bit in `ind_tbl` accepts it with miss clear.
- R9: A frame matched by nothing is accepted with miss set when `prom_en` is high, and rejected otherwise. Miss is never set without `prom_en`.
- R10: The decision strobe appears two clock cycles after the deciding byte is sampled. The deciding byte is byte 6 in general, byte 16 for a flow-control candidate, or the last byte if the frame ends before that byte.
- R11: Each frame yields at most one strobe. A frame that ends before 6 bytes is rejected. A start of frame discards an undecided earlier frame, and that earlier frame gets no strobe.
- R12: After reset, and in every cycle without a strobe, `dec_valid`, `dec_accept`, `dec_miss` and `dec_pause` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | Present byte is the first of a frame |
| rx_eof | input | 1 | Present byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| sta_addr | input | 48 | Station address, first byte in [47:40] |
| ind_tbl | input | 64 | Individual hash table |
| grp_tbl | input | 64 | Group hash table |
| bc_rej | input | 1 | Broadcast reject control |
| prom_en | input | 1 | Promiscuous mode |
| fc_en | input | 1 | Flow control enable |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame is kept |
| dec_miss | output | 1 | Frame kept only by the promiscuous fallback |
| dec_pause | output | 1 | Frame recognised as a flow-control frame and dropped |

## Verification
The hardest situation to reach is a flow-control candidate that never reaches byte 16. In one case the frame ends early and must be decided at its last byte. In the other case a new start of frame arrives first and must suppress any strobe for the abandoned frame. The stimulus covers these cases by sending a frame to the station address with flow control on that ends after 14 bytes. It then sends a 10-byte candidate with no end marker, followed at once by a normal frame. The scoreboard expects exactly one verdict, and that verdict must arrive in the cycle computed for the normal frame.

// File: rtl/rxf_pkg.sv
// Shared constants, verdict type and CRC step for the receive address filter.
// Assumes a byte-serial stream with the first destination byte sent first.
package rxf_pkg;
    localparam int DA_BYTES  = 6;
    localparam int HDR_BYTES = 16;
    localparam int DA_W      = DA_BYTES * 8;
    localparam logic [DA_W-1:0] FC_RESERVED_DA = 48'h0180C2000001;

    typedef struct packed {
        logic accept;
        logic miss;
        logic pause;
    } verdict_t;

    // Advance a CRC-32 (0x04C11DB7, shift-left form) by one byte, LSB first.
    function automatic logic [31:0] crc_step(input logic [31:0] c_in, input logic [7:0] b);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[31] ^ b[i];
            c  = {c[30:0], 1'b0};
            if (fb) c = c ^ 32'h04C11DB7;
        end
        return c;
    endfunction
endpackage

// File: rtl/rxf_da_capture.sv
// Counts bytes of the current frame, assembles the destination address and
// its CRC. Assumes rx_sof and rx_eof are only meaningful with rx_valid.
module rxf_da_capture #(
    parameter int CW = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_data,
    output logic [CW-1:0]           idx_in,
    output logic [CW-1:0]           cnt,
    output logic [rxf_pkg::DA_W-1:0] da,
    output logic [31:0]             crc,
    output logic                    byte_tick,
    output logic                    end_tick
);
    import rxf_pkg::*;
    localparam logic [CW-1:0] SAT   = CW'(HDR_BYTES + 1);
    localparam logic [CW-1:0] DA_LAST = CW'(DA_BYTES);

    // Position of the byte on the input this cycle, saturating past the header.
    assign idx_in = rx_sof ? CW'(1) : ((cnt == SAT) ? SAT : cnt + 1'b1);

    // Register count, address shift, CRC and per-byte event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            da        <= '0;
            crc       <= '1;
            byte_tick <= 1'b0;
            end_tick  <= 1'b0;
        end else begin
            byte_tick <= rx_valid;
            end_tick  <= rx_valid && rx_eof;
            if (rx_valid) begin
                cnt <= idx_in;
                if (idx_in <= DA_LAST) begin
                    da  <= rx_sof ? {{(DA_W-8){1'b0}}, rx_data} : {da[DA_W-9:0], rx_data};
                    crc <= crc_step(rx_sof ? 32'hFFFF_FFFF : crc, rx_data);
                end
            end
        end
    end
endmodule

// File: rtl/rxf_pause_match.sv
// Tracks whether the type and opcode bytes of the frame equal the
// flow-control values. Assumes idx_in from the capture stage.
module rxf_pause_match #(
    parameter int          CW     = 5,
    parameter logic [15:0] ETYPE  = 16'h8808,
    parameter logic [15:0] OPCODE = 16'h0001
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [7:0]    rx_data,
    input  logic [CW-1:0] idx_in,
    output logic          hdr_ok
);
    import rxf_pkg::*;
    localparam logic [CW-1:0] P0 = CW'(HDR_BYTES - 3);
    localparam logic [CW-1:0] P1 = CW'(HDR_BYTES - 2);
    localparam logic [CW-1:0] P2 = CW'(HDR_BYTES - 1);
    localparam logic [CW-1:0] P3 = CW'(HDR_BYTES);

    logic [7:0] want;

    // Select the expected byte for the current header position.
    always_comb begin
        unique case (idx_in)
            P0:      want = ETYPE[15:8];
            P1:      want = ETYPE[7:0];
            P2:      want = OPCODE[15:8];
            default: want = OPCODE[7:0];
        endcase
    end

    // Accumulate the comparison over the four header bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_ok <= 1'b0;
        end else if (rx_valid && idx_in >= P0 && idx_in <= P3) begin
            hdr_ok <= (rx_data == want) && ((idx_in == P0) || hdr_ok);
        end
    end
endmodule

// File: rtl/rxf_decide.sv
// Applies the acceptance priority to the captured address and issues one
// registered verdict per frame. Assumes configuration is stable in a frame.
module rxf_decide #(
    parameter int CW     = 5,
    parameter int HASH_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CW-1:0]             cnt,
    input  logic [rxf_pkg::DA_W-1:0]  da,
    input  logic [31:0]               crc,
    input  logic                      byte_tick,
    input  logic                      end_tick,
    input  logic                      hdr_ok,
    input  logic [rxf_pkg::DA_W-1:0]  sta_addr,
    input  logic [(1<<HASH_W)-1:0]    ind_tbl,
    input  logic [(1<<HASH_W)-1:0]    grp_tbl,
    input  logic                      bc_rej,
    input  logic                      prom_en,
    input  logic                      fc_en,
    output logic                      dec_valid,
    output rxf_pkg::verdict_t         dec
);
    import rxf_pkg::*;
    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] DAN = CW'(DA_BYTES);
    localparam logic [CW-1:0] HDN = CW'(HDR_BYTES);

    logic        active, pwait;
    logic [HASH_W-1:0] hidx;
    logic        is_bc, is_mc, cand, first, live, pw;
    verdict_t    fallback, base, outv;
    logic        issue, enter;

    assign hidx  = crc[31 -: HASH_W];
    assign is_bc = &da;
    assign is_mc = da[DA_W-8];
    assign cand  = fc_en && !is_bc && ((da == FC_RESERVED_DA) || (da == sta_addr));
    assign first = byte_tick && (cnt == ONE);
    assign live  = first || active;
    assign pw    = pwait && !first;

    // Verdict for the address alone, following the fixed priority.
    always_comb begin
        fallback = prom_en ? '{accept: 1'b1, miss: 1'b1, pause: 1'b0} : '0;
        if (is_bc)
            base = bc_rej ? fallback : '{accept: 1'b1, miss: 1'b0, pause: 1'b0};
        else if (is_mc && fc_en)
            base = (da == FC_RESERVED_DA) ? '{accept: 1'b1, miss: 1'b0, pause: 1'b0} : fallback;
        else if (is_mc)
            base = grp_tbl[hidx] ? '{accept: 1'b1, miss: 1'b0, pause: 1'b0} : fallback;
        else
            base = ((da == sta_addr) || ind_tbl[hidx]) ? '{accept: 1'b1, miss: 1'b0, pause: 1'b0} : fallback;
    end

    // Pick the event that decides this frame, if any, this cycle.
    always_comb begin
        issue = 1'b0;
        enter = 1'b0;
        outv  = '0;
        if (live && !pw && end_tick && cnt < DAN) begin
            issue = 1'b1;
        end else if (live && !pw && byte_tick && cnt == DAN) begin
            if (cand && !end_tick) enter = 1'b1;
            else begin issue = 1'b1; outv = base; end
        end else if (pw && byte_tick && cnt == HDN) begin
            issue = 1'b1;
            outv  = hdr_ok ? '{accept: 1'b0, miss: 1'b0, pause: 1'b1} : base;
        end else if (pw && end_tick) begin
            issue = 1'b1;
            outv  = base;
        end
    end

    // Frame progress flags and the registered verdict strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active    <= 1'b0;
            pwait     <= 1'b0;
            dec_valid <= 1'b0;
            dec       <= '0;
        end else begin
            active    <= issue ? 1'b0 : live;
            pwait     <= issue ? 1'b0 : (enter || pw);
            dec_valid <= issue;
            dec       <= outv;
        end
    end
endmodule

// File: rtl/rx_addr_filter.sv
// Top of the receive destination address filter: capture, flow-control
// header match and priority decision. Assumes one byte per valid cycle.
module rx_addr_filter #(
    parameter int          HASH_W       = 6,
    parameter logic [15:0] PAUSE_ETYPE  = 16'h8808,
    parameter logic [15:0] PAUSE_OPCODE = 16'h0001
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   rx_valid,
    input  logic                   rx_sof,
    input  logic                   rx_eof,
    input  logic [7:0]             rx_data,
    input  logic [47:0]            sta_addr,
    input  logic [(1<<HASH_W)-1:0] ind_tbl,
    input  logic [(1<<HASH_W)-1:0] grp_tbl,
    input  logic                   bc_rej,
    input  logic                   prom_en,
    input  logic                   fc_en,
    output logic                   dec_valid,
    output logic                   dec_accept,
    output logic                   dec_miss,
    output logic                   dec_pause
);
    import rxf_pkg::*;
    localparam int CW = $clog2(HDR_BYTES + 2);

    logic [CW-1:0]   idx_in, cnt;
    logic [DA_W-1:0] da;
    logic [31:0]     crc;
    logic            byte_tick, end_tick, hdr_ok;
    verdict_t        dec;

    rxf_da_capture #(.CW(CW)) u_cap (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .idx_in(idx_in), .cnt(cnt),
        .da(da), .crc(crc), .byte_tick(byte_tick), .end_tick(end_tick)
    );

    rxf_pause_match #(.CW(CW), .ETYPE(PAUSE_ETYPE), .OPCODE(PAUSE_OPCODE)) u_pm (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .idx_in(idx_in), .hdr_ok(hdr_ok)
    );

    rxf_decide #(.CW(CW), .HASH_W(HASH_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .da(da), .crc(crc),
        .byte_tick(byte_tick), .end_tick(end_tick), .hdr_ok(hdr_ok),
        .sta_addr(sta_addr), .ind_tbl(ind_tbl), .grp_tbl(grp_tbl),
        .bc_rej(bc_rej), .prom_en(prom_en), .fc_en(fc_en),
        .dec_valid(dec_valid), .dec(dec)
    );

    assign dec_accept = dec.accept;
    assign dec_miss   = dec.miss;
    assign dec_pause  = dec.pause;
endmodule

// File: rtl/rxf_checker.sv
// Property checker for rx_addr_filter, attached by bind below. Watches the
// strobe against configuration and frame starts.
module rxf_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic rx_sof,
    input logic prom_en,
    input logic fc_en,
    input logic dec_valid,
    input logic dec_accept,
    input logic dec_miss,
    input logic dec_pause
);
    logic sof_d, decided;

    // Remember whether the current frame already produced its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sof_d   <= 1'b0;
            decided <= 1'b0;
        end else begin
            sof_d   <= rx_valid && rx_sof;
            decided <= sof_d ? 1'b0 : (decided || dec_valid);
        end
    end

    p_miss_needs_prom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_miss |-> $past(prom_en) && dec_accept);
    p_pause_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid && dec_pause |-> !dec_accept && !dec_miss && $past(fc_en));
    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !decided);
    p_quiet_flags_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(dec_accept || dec_miss || dec_pause));
    p_reset_quiet_r12: assert property (@(posedge clk)
        $past(!rst_n) |-> !dec_valid);
endmodule

bind rx_addr_filter rxf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .prom_en(prom_en), .fc_en(fc_en), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_miss(dec_miss), .dec_pause(dec_pause)
);

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_sof, rx_eof;
    logic [7:0]  rx_data;
    logic [47:0] sta_addr;
    logic [63:0] ind_tbl, grp_tbl;
    logic        bc_rej, prom_en, fc_en;
    logic        dec_valid, dec_accept, dec_miss, dec_pause;

    localparam logic [47:0] RES_DA = 48'h0180C2000001;
    localparam logic [47:0] BCAST  = 48'hFFFFFFFFFFFF;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    logic [2:0] q_v[$];
    int         q_c[$];
    string      q_t[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rx_addr_filter dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .sta_addr(sta_addr),
        .ind_tbl(ind_tbl), .grp_tbl(grp_tbl), .bc_rej(bc_rej),
        .prom_en(prom_en), .fc_en(fc_en), .dec_valid(dec_valid),
        .dec_accept(dec_accept), .dec_miss(dec_miss), .dec_pause(dec_pause)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Hash index via the reflected CRC form, bit-reversed (R5).
    function automatic logic [5:0] hidx(input logic [47:0] a);
        logic [31:0] r = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            r = r ^ {24'h0, a[47-8*k -: 8]};
            for (int j = 0; j < 8; j++) r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return {r[0], r[1], r[2], r[3], r[4], r[5]};
    endfunction

    function automatic logic [7:0] fbyte(input logic [47:0] a, input logic [15:0] et,
                                         input logic [15:0] op, input int i);
        if (i <= 6)  return a[47-8*(i-1) -: 8];
        if (i <= 12) return 8'(8'h02 + i);
        if (i == 13) return et[15:8];
        if (i == 14) return et[7:0];
        if (i == 15) return op[15:8];
        if (i == 16) return op[7:0];
        return 8'(i);
    endfunction

    // Driver: computes the expected verdict from the requirements, drives the frame.
    task automatic send(input logic [47:0] a, input logic [15:0] et, input logic [15:0] op,
                        input int len, input bit ends, input string tag);
        logic [2:0] fb, bv, ev;   // {accept, miss, pause}
        bit bc, mc, cand, has;
        int at;
        bc = (a == BCAST);
        mc = a[40];
        fb = prom_en ? 3'b110 : 3'b000;
        if (bc)            bv = bc_rej ? fb : 3'b100;
        else if (mc && fc_en) bv = (a == RES_DA) ? 3'b100 : fb;
        else if (mc)       bv = grp_tbl[hidx(a)] ? 3'b100 : fb;
        else               bv = (a == sta_addr || ind_tbl[hidx(a)]) ? 3'b100 : fb;
        cand = fc_en && !bc && (a == RES_DA || a == sta_addr);
        has = 1; at = 6; ev = bv;
        if (len < 6) begin has = ends; at = len; ev = 3'b000; end
        else if (cand) begin
            if (len >= 16) begin
                at = 16;
                ev = (et == 16'h8808 && op == 16'h0001) ? 3'b001 : bv;
            end else begin has = ends; at = len; end
        end
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 1);
            rx_eof   = ends && (i == len);
            rx_data  = fbyte(a, et, op, i);
            if (has && i == at) begin
                q_v.push_back(ev); q_c.push_back(cyc + 2); q_t.push_back(tag);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
        if (ends) repeat (4) @(negedge clk);
    endtask

    // Monitor: pops expected verdicts as strobes appear and compares.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && dec_valid === 1'b1) begin
            if (q_v.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11: actual unexpected strobe expected none");
            end else begin
                logic [2:0] e;
                int c;
                string t;
                e = q_v.pop_front(); c = q_c.pop_front(); t = q_t.pop_front();
                chk({t, " verdict"}, {dec_accept, dec_miss, dec_pause}, e);
                chk({"R10 timing ", t}, cyc, c);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [47:0] uc_other, mc_addr;
        rst_n = 1'b0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0;
        sta_addr = 48'h021122334455; ind_tbl = '0; grp_tbl = '0;
        bc_rej = 0; prom_en = 0; fc_en = 0;
        uc_other = 48'h0A0B0C0D0E0F;
        mc_addr  = 48'h01005E102030;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset outputs", {dec_valid, dec_accept, dec_miss, dec_pause}, 0);

        send(BCAST, 16'h0800, 0, 20, 1, "R2 broadcast accept");
        bc_rej = 1;
        send(BCAST, 16'h0800, 0, 20, 1, "R3 broadcast reject");
        prom_en = 1;
        send(BCAST, 16'h0800, 0, 20, 1, "R3 broadcast promiscuous miss");
        prom_en = 0; bc_rej = 0;

        send(sta_addr, 16'h0800, 0, 20, 1, "R8 station exact");
        ind_tbl = 64'd1 << hidx(uc_other);
        send(uc_other, 16'h0800, 0, 20, 1, "R8 R5 individual hash hit");
        ind_tbl = ~(64'd1 << hidx(uc_other));
        send(uc_other, 16'h0800, 0, 20, 1, "R9 individual hash miss reject");
        prom_en = 1;
        send(uc_other, 16'h0800, 0, 20, 1, "R9 promiscuous miss");
        prom_en = 0;

        grp_tbl = 64'd1 << hidx(mc_addr);
        send(mc_addr, 16'h0800, 0, 20, 1, "R4 R5 group hash hit");
        grp_tbl = ~(64'd1 << hidx(mc_addr));
        send(mc_addr, 16'h0800, 0, 20, 1, "R4 group hash miss");
        ind_tbl = '1; grp_tbl = '0;
        send(mc_addr, 16'h0800, 0, 20, 1, "R1 multicast ignores individual table");

        send(sta_addr, 16'h8808, 16'h0001, 20, 1, "R7 no flow control accepts at once");
        fc_en = 1; grp_tbl = '1;
        send(RES_DA, 16'h8808, 16'h0001, 64, 1, "R6 reserved pause dropped");
        send(RES_DA, 16'h8808, 16'h0002, 64, 1, "R6 reserved non-pause accepted");
        send(mc_addr, 16'h0800, 0, 20, 1, "R6 other multicast falls back");
        send(sta_addr, 16'h8808, 16'h0001, 18, 1, "R7 station pause dropped");
        send(sta_addr, 16'h8808, 16'h0001, 14, 1, "R10 candidate ends early");
        send(BCAST, 16'h8808, 16'h0001, 20, 1, "R2 broadcast under flow control");

        send(uc_other, 0, 0, 4, 1, "R11 short frame reject");
        send(sta_addr, 16'h8808, 16'h0001, 10, 0, "R11 abandoned candidate");
        send(uc_other, 16'h0800, 0, 20, 1, "R11 frame after abandoned");

        repeat (10) @(negedge clk);
        chk("R11 every expected strobe seen", q_v.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule